// File: doc/BRIEF.md
# Eight-pin GPIO port with timer output-compare override

This block is one general-purpose I/O port of eight pins. Software reaches it through a small register interface with four addresses. The registers hold the pin direction, a per-pin reduced-drive select, the output latch, and a read-only view of the pin levels. The pin levels pass through a two-flop synchronizer before anything inside the block uses them.

A timer can take over any pin. It does this through a per-pin output-compare enable and a per-pin compare level. While the enable is high, the pin drives the compare level and its output enable is forced on. The stored direction bit is left untouched, and direction control goes back to it as soon as the enable drops. The synchronized pin level is always passed to the timer's input-capture logic, whatever the pin's direction.

Register map (`bus_addr`):
- 0 is the output latch. A read returns the latch for output pins and the synchronized level for input pins.
- 1 is the direction register. A bit set to 1 makes the pin an output.
- 2 is the reduced-drive select.
- 3 is the synchronized pin level. It is read-only.

`bus_rdata` shows the addressed register while `bus_sel` is high and is zero otherwise.

Top module: `gpio_timer_port`

## Requirements
- R1: After reset the direction, reduced-drive and output-latch registers are all zero. `pad_oe` and `drive_sel` are then zero.
- R2: For a pin whose timer enable is low, `pad_oe` equals its direction bit and `pad_out` equals its latch bit.
- R3: Addresses 1 and 2 can be written and read back at any time. A write takes effect at the next clock edge.
- R4: For a pin whose timer enable is high, `pad_oe` is 1 and `pad_out` equals that pin's `tmr_oc_lvl` bit.
- R5: A timer override never changes the stored direction bit. A read of address 1 during or after an override returns the last value written.
- R6: When a pin's timer enable falls, its `pad_oe` returns to the stored direction bit in the same cycle.
- R7: `tmr_ic_lvl` equals `pad_in` as sampled two clock edges earlier, for input and output pins alike.
- R8: A read of address 3 returns the same synchronized level that `tmr_ic_lvl` shows.
- R9: A read of address 0 returns, bit by bit, the latch for pins whose direction bit is 1. It returns the synchronized level for pins whose direction bit is 0.
- R10: `drive_sel` always equals the reduced-drive register. It changes only on a write to address 2.
- R11: A write strobe with `bus_sel` low changes no register. A write to address 3 also changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Level driven on each pin |
| pad_oe | output | 8 | Output enable per pin |
| drive_sel | output | 8 | Reduced-drive select per pin |
| tmr_oc_en | input | 8 | Timer output-compare enable per pin |
| tmr_oc_lvl | input | 8 | Timer compare output level per pin |
| tmr_ic_lvl | output | 8 | Synchronized pin level to input capture |

## Verification
The hardest situation to reach is an override that overlaps a direction write. The stored bit must then differ from the forced enable, and it must come back unchanged when the timer lets go. Random stimulus changes the timer enables, the pin levels and the bus writes in the same cycles, so overrides and direction writes overlap again and again. A directed step writes the direction register while every pin is forced, then releases the timer. The two-cycle synchronizer delay is checked edge by edge after a directed pin change and again on every random cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        REG_LATCH = 2'd0,
        REG_DIR   = 2'd1,
        REG_DRIVE = 2'd2,
        REG_LEVEL = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] level_sync,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] drive_q
);
    gpio_reg_e reg_sel;
    logic      wr_en;
    logic [WIDTH-1:0] rd_mux;

    assign reg_sel = gpio_reg_e'(bus_addr);
    assign wr_en   = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            drive_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_LATCH: latch_q <= bus_wdata;
                REG_DIR:   dir_q   <= bus_wdata;
                REG_DRIVE: drive_q <= bus_wdata;
                REG_LEVEL: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_LATCH: rd_mux = (dir_q & latch_q) | (~dir_q & level_sync);
            REG_DIR:   rd_mux = dir_q;
            REG_DRIVE: rd_mux = drive_q;
            REG_LEVEL: rd_mux = level_sync;
        endcase
    end

    assign bus_rdata = bus_sel ? rd_mux : '0;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] force_en,
    input  logic [WIDTH-1:0] force_lvl,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            if (force_en[i]) begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = force_lvl[i];
            end else begin
                pad_oe[i]  = dir_q[i];
                pad_out[i] = latch_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] drive_sel,
    input  logic [WIDTH-1:0] tmr_oc_en,
    input  logic [WIDTH-1:0] tmr_oc_lvl,
    output logic [WIDTH-1:0] tmr_ic_lvl
);
    logic [WIDTH-1:0] level_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] drive_q;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (level_sync)
    );

    gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .level_sync (level_sync),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .drive_q    (drive_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .force_en  (tmr_oc_en),
        .force_lvl (tmr_oc_lvl),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    assign drive_sel  = drive_q;
    assign tmr_ic_lvl = level_sync;
endmodule

// File: rtl/gpio_timer_port_chk.sv
module gpio_timer_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] drive_sel,
    input logic [WIDTH-1:0] tmr_oc_en,
    input logic [WIDTH-1:0] tmr_oc_lvl,
    input logic [WIDTH-1:0] tmr_ic_lvl
);
    logic [1:0] edges_since_rst;
    logic       wr_dir;
    logic       wr_drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges_since_rst <= 2'd0;
        else if (edges_since_rst != 2'd2) edges_since_rst <= edges_since_rst + 2'd1;
    end

    assign wr_dir   = bus_sel && bus_wr && (bus_addr == 2'd1);
    assign wr_drive = bus_sel && bus_wr && (bus_addr == 2'd2);

    assert_force_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & tmr_oc_en) == tmr_oc_en) && (((pad_out ^ tmr_oc_lvl) & tmr_oc_en) == '0));

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> ((pad_oe & ~tmr_oc_en) == ($past(bus_wdata) & ~tmr_oc_en)));

    assert_dir_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dir && (tmr_oc_en == '0)) |=> ((tmr_oc_en != '0) || $stable(pad_oe)));

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2) |-> (tmr_ic_lvl == $past(pad_in, 2)));

    assert_level_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == 2'd3) |-> (bus_rdata == tmr_ic_lvl));

    assert_drive_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_drive |=> $stable(drive_sel));
endmodule

bind gpio_timer_port gpio_timer_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_timer_port_bench.sv
module gpio_timer_port_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] drive_sel;
    logic [W-1:0] tmr_oc_en = '0;
    logic [W-1:0] tmr_oc_lvl = '0;
    logic [W-1:0] tmr_ic_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    gpio_timer_port #(.WIDTH(W)) u_gpio_timer_port (.*);

    // Reference state, updated from the requirements at each rising edge
    logic [W-1:0] m_lat, m_dir, m_drv, m_s1, m_s2;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat <= '0; m_dir <= '0; m_drv <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    2'd0: m_lat <= bus_wdata;
                    2'd1: m_dir <= bus_wdata;
                    2'd2: m_drv <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [W-1:0] exp_oe();
        return m_dir | tmr_oc_en;
    endfunction

    function automatic logic [W-1:0] exp_out();
        return (tmr_oc_en & tmr_oc_lvl) | (~tmr_oc_en & m_lat);
    endfunction

    function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return (m_dir & m_lat) | (~m_dir & m_s2);
            2'd1: return m_dir;
            2'd2: return m_drv;
            default: return m_s2;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1CE5_0A17));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", pad_oe, '0);
        chk("R1", drive_sel, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1", 2'd1, '0);
        rd_chk("R1", 2'd2, '0);

        // R3 / R10: readback and drive export
        wr(2'd1, 8'hA5);
        rd_chk("R3", 2'd1, 8'hA5);
        wr(2'd2, 8'h3C);
        rd_chk("R3", 2'd2, 8'h3C);
        chk("R10", drive_sel, 8'h3C);

        // R11: ignored writes
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R11", 2'd1, 8'hA5);
        wr(2'd3, 8'hFF);
        rd_chk("R11", 2'd0, exp_rd(2'd0));
        rd_chk("R11", 2'd1, 8'hA5);
        rd_chk("R11", 2'd2, 8'h3C);

        // R5 / R6: direction write while every pin is forced, then release
        wr(2'd0, 8'h0F);
        @(negedge clk);
        tmr_oc_en = 8'hFF; tmr_oc_lvl = 8'h96;
        #1;
        chk("R4", pad_oe, 8'hFF);
        chk("R4", pad_out, 8'h96);
        wr(2'd1, 8'h0F);
        rd_chk("R5", 2'd1, 8'h0F);
        chk("R5", pad_oe, 8'hFF);
        tmr_oc_en = 8'h00;
        #1;
        chk("R6", pad_oe, 8'h0F);
        chk("R2", pad_out, 8'h0F);
        rd_chk("R5", 2'd1, 8'h0F);

        // R7: two-edge latency on a pin change
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        chk("R7", tmr_ic_lvl, m_s2);
        @(negedge clk);
        chk("R7", tmr_ic_lvl, 8'h5A);
        rd_chk("R8", 2'd3, 8'h5A);
        rd_chk("R9", 2'd0, 8'h5F);

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            pad_in     = W'($urandom);
            tmr_oc_en  = ($urandom % 3 == 0) ? W'($urandom) : '0;
            tmr_oc_lvl = W'($urandom);
            bus_addr   = 2'($urandom);
            bus_wdata  = W'($urandom);
            bus_sel    = ($urandom % 4) != 0;
            bus_wr     = ($urandom % 2) != 0;
            #1;
            chk("R2", pad_oe, exp_oe());
            chk("R4", pad_out, exp_out());
            chk("R7", tmr_ic_lvl, m_s2);
            chk("R10", drive_sel, m_drv);
            if (bus_sel) begin
                case (bus_addr)
                    2'd0: chk("R9", bus_rdata, exp_rd(2'd0));
                    2'd1: chk("R5", bus_rdata, exp_rd(2'd1));
                    2'd2: chk("R3", bus_rdata, exp_rd(2'd2));
                    default: chk("R8", bus_rdata, exp_rd(2'd3));
                endcase
            end else begin
                chk("R11", bus_rdata, '0);
            end
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule